// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block is a configuration slave for a shared serial bus. A host starts each 16-bit frame with a one-bit-wide pulse on the frame-sync input and sends the bits most significant first. The frame carries a direction bit, a two-bit device identifier, a four-bit register address, a spacer bit and one data byte. Up to four copies of the block can sit on one bus. Each copy has its own identifier set by two strap inputs and acts only on frames that carry that identifier. Writes go into a small register file. A read frame returns the selected register on the serial data output in the second half of the same frame.

The block makes its own serial clock by dividing the core clock. It samples frame-sync and serial data when that clock rises, and it changes its serial data output when that clock falls. Only the copy strapped to identifier 0 enables its serial clock pad toward the host. The register contents go to the rest of the chip as a six-bit control vector and a 16-bit receive offset word.

The frame sequencer has five states. IDLE waits for frame-sync. HEAD collects the eight header bits. WDATA collects a write byte. RDOUT shifts out a read byte. SKIP lets a frame for another device go by. The transitions are: *start* (IDLE to HEAD, frame-sync high on a rising edge); *to_write*, *to_read* and *to_skip* (from HEAD on the eighth bit, chosen by identifier match and the direction bit); and *frame_end* (WDATA, RDOUT or SKIP back to IDLE on the sixteenth bit).

Top module: `sctl_port`

## Requirements
- R1: `sclk_o` is a square wave with a period of 2*SCLK_HALF core clocks, low out of reset. `sclk_oe` is high exactly when `dev_addr` is 0.
- R2: In IDLE, frame-sync sampled high on a rising serial clock edge starts a frame. The bit sampled on that same edge is frame bit 15. A frame is exactly 16 rising edges long. Frame-sync is ignored while a frame is in progress. A new frame can start on the rising edge right after the last bit.
- R3: Frame layout, most significant bit first: bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the device identifier, bits 12:9 are the register address, bit 8 is sent as zero, and bits 7:0 are the data.
- R4: A frame whose identifier differs from `dev_addr` changes no register, and `sdo_oe` stays low for the whole frame.
- R5: A matched write to address 7 loads data bits 5:0 into `misc_ctl[5:0]` on the rising edge of frame bit 0. The bit meanings are: 0 transmit high-pass enable, 1 receive power-down, 2 transmit power-down, 3 analog loopback, 4 digital loopback, 5 transmit read-back test. Data bits 7:6 are discarded, and address 7 reads them back as zero.
- R6: A matched write to address 9 loads `rx_offset[7:0]`. A matched write to address 10 loads `rx_offset[15:8]`.
- R7: Writes to any other address, including 8, change nothing. Reads from those addresses return 0x00.
- R8: On a matched read, `sdo_oe` rises on the falling serial clock edge after frame bit 8. The register byte is then presented most significant bit first, one bit per serial clock period, so that each bit is valid at the rising edges of frame bits 7..0. `sdo_oe` drops on the next falling edge. A read changes no register.
- R9: After reset, `misc_ctl` and `rx_offset` are zero and `sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the serial clock is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 2 | Strapped device identifier |
| fs | input | 1 | Frame-sync from the host |
| sdi | input | 1 | Serial data from the host |
| sclk_o | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Pad enable for `sclk_o` (identifier 0 only) |
| sdo_o | output | 1 | Serial read data |
| sdo_oe | output | 1 | Pad enable for `sdo_o` |
| misc_ctl | output | 6 | Control bits held at address 7 |
| rx_offset | output | 16 | Receive offset word (addresses 10 and 9) |

## Verification
Two pieces of work can land on the same rising edge. The first is the final-bit register write that closes one frame. The second is the decision on the next frame, either frame-sync starting it right after the last bit or the header-complete edge of that next frame loading the read buffer. The random bench often leaves no idle bit between frames, and it often follows a write with a read of the same address, so a register written on one edge has to be read back from the very next frame. It judges each frame by the captured read byte, by the number of bit times `sdo_oe` was high, and by the register outputs compared against a bench model.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    localparam int FRAME_BITS = 16;
    localparam int HDR_BITS   = 8;
    localparam int DATA_BITS  = 8;
    localparam int ADDR_W     = 4;
    localparam int ID_W       = 2;
    localparam int MISC_W     = 6;
    localparam int OFS_BYTES  = 2;
    localparam int BCNT_W     = $clog2(FRAME_BITS);

    // header field positions inside the 8-bit header
    localparam int H_RW   = 7;
    localparam int H_ID_L = 5;
    localparam int H_AD_L = 1;

    localparam logic [ADDR_W-1:0] A_MISC   = 4'd7;
    localparam logic [ADDR_W-1:0] A_OFS_LO = 4'd9;

    localparam logic [ID_W-1:0] CLK_MASTER_ID = '0;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HEAD  = 3'd1,
        ST_WDATA = 3'd2,
        ST_RDOUT = 3'd3,
        ST_SKIP  = 3'd4
    } sctl_state_e;

endpackage

// File: rtl/sctl_sclk_gen.sv
module sctl_sclk_gen #(
    parameter int SCLK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(SCLK_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          wrap;

    assign wrap     = (cnt_q == LAST);
    assign rise_stb = wrap && !sclk_q;
    assign fall_stb = wrap && sclk_q;
    assign sclk     = sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            sclk_q <= !sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sctl_frame_fsm.sv
module sctl_frame_fsm
    import sctl_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rise_stb,
    input  logic                   fall_stb,
    input  logic                   fs,
    input  logic                   sdi,
    input  logic [ID_W-1:0]        dev_addr,
    output logic [ADDR_W-1:0]      rd_addr,
    input  logic [DATA_BITS-1:0]   rd_data,
    output logic                   wr_stb,
    output logic [ADDR_W-1:0]      wr_addr,
    output logic [DATA_BITS-1:0]   wr_data,
    output logic                   sdo_o,
    output logic                   sdo_oe,
    output sctl_state_e            state_o,
    output logic [BCNT_W-1:0]      bcnt_o
);
    localparam logic [BCNT_W-1:0] HDR_LAST   = BCNT_W'(HDR_BITS - 1);
    localparam logic [BCNT_W-1:0] FRAME_LAST = BCNT_W'(FRAME_BITS - 1);

    sctl_state_e             state_q, state_d;
    logic [BCNT_W-1:0]       bcnt_q;
    logic [HDR_BITS-1:0]     hdr_q;
    logic [HDR_BITS-1:0]     hdr_nxt;
    logic [DATA_BITS-2:0]    dat_q;
    logic [DATA_BITS-1:0]    obuf_q;
    logic                    sdo_q;
    logic                    sdo_oe_q;
    logic                    id_hit;
    logic                    hdr_done;
    logic                    frame_done;

    assign hdr_nxt    = {hdr_q[HDR_BITS-2:0], sdi};
    assign id_hit     = (hdr_nxt[H_ID_L +: ID_W] == dev_addr);
    assign hdr_done   = rise_stb && (state_q == ST_HEAD) && (bcnt_q == HDR_LAST);
    assign frame_done = rise_stb && (bcnt_q == FRAME_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rise_stb && fs) state_d = ST_HEAD;              // start
            ST_HEAD:  if (hdr_done) begin
                          if (!id_hit)              state_d = ST_SKIP;    // to_skip
                          else if (hdr_nxt[H_RW])   state_d = ST_RDOUT;   // to_read
                          else                      state_d = ST_WDATA;   // to_write
                      end
            ST_WDATA,
            ST_RDOUT,
            ST_SKIP:  if (frame_done) state_d = ST_IDLE;                  // frame_end
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // receive datapath: bit count, header and write data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt_q <= '0;
            hdr_q  <= '0;
            dat_q  <= '0;
        end else if (rise_stb) begin
            if (state_q == ST_IDLE) begin
                if (fs) begin
                    bcnt_q <= BCNT_W'(1);
                    hdr_q  <= {{(HDR_BITS-1){1'b0}}, sdi};
                end
            end else begin
                bcnt_q <= bcnt_q + 1'b1;
                if (state_q == ST_HEAD)  hdr_q <= hdr_nxt;
                if (state_q == ST_WDATA) dat_q <= {dat_q[DATA_BITS-3:0], sdi};
            end
        end
    end

    // output process: read buffer and serial data pad
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obuf_q   <= '0;
            sdo_q    <= 1'b0;
            sdo_oe_q <= 1'b0;
        end else if (hdr_done && id_hit && hdr_nxt[H_RW]) begin
            obuf_q <= rd_data;
        end else if (fall_stb) begin
            if (state_q == ST_RDOUT) begin
                sdo_q    <= obuf_q[DATA_BITS-1];
                obuf_q   <= {obuf_q[DATA_BITS-2:0], 1'b0};
                sdo_oe_q <= 1'b1;
            end else begin
                sdo_q    <= 1'b0;
                sdo_oe_q <= 1'b0;
            end
        end
    end

    assign rd_addr = hdr_nxt[H_AD_L +: ADDR_W];
    assign wr_stb  = frame_done && (state_q == ST_WDATA);
    assign wr_addr = hdr_q[H_AD_L +: ADDR_W];
    assign wr_data = {dat_q, sdi};
    assign sdo_o   = sdo_q;
    assign sdo_oe  = sdo_oe_q;
    assign state_o = state_q;
    assign bcnt_o  = bcnt_q;
endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile
    import sctl_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_stb,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_BITS-1:0]         wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_BITS-1:0]         rd_data,
    output logic [MISC_W-1:0]            misc_ctl,
    output logic [OFS_BYTES*DATA_BITS-1:0] rx_offset
);
    logic [MISC_W-1:0]    misc_q;
    logic [DATA_BITS-1:0] ofs_q [OFS_BYTES];
    logic [DATA_BITS-1:0] ofs_rd [OFS_BYTES];
    logic [OFS_BYTES-1:0] ofs_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              misc_q <= '0;
        else if (wr_stb && wr_addr == A_MISC)    misc_q <= wr_data[MISC_W-1:0];
    end

    for (genvar g = 0; g < OFS_BYTES; g++) begin : g_ofs
        localparam logic [ADDR_W-1:0] MY_ADDR = A_OFS_LO + ADDR_W'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           ofs_q[g] <= '0;
            else if (wr_stb && wr_addr == MY_ADDR) ofs_q[g] <= wr_data;
        end
        assign ofs_sel[g]                          = (rd_addr == MY_ADDR);
        assign ofs_rd[g]                           = ofs_sel[g] ? ofs_q[g] : '0;
        assign rx_offset[g*DATA_BITS +: DATA_BITS] = ofs_q[g];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_MISC) rd_data = {{(DATA_BITS-MISC_W){1'b0}}, misc_q};
        for (int i = 0; i < OFS_BYTES; i++) rd_data = rd_data | ofs_rd[i];
    end

    assign misc_ctl = misc_q;
endmodule

// File: rtl/sctl_port.sv
module sctl_port
    import sctl_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  dev_addr,
    input  logic        fs,
    input  logic        sdi,
    output logic        sclk_o,
    output logic        sclk_oe,
    output logic        sdo_o,
    output logic        sdo_oe,
    output logic [5:0]  misc_ctl,
    output logic [15:0] rx_offset
);
    logic                  rise_w;
    logic                  fall_w;
    logic [ADDR_W-1:0]     rd_addr_w;
    logic [DATA_BITS-1:0]  rd_data_w;
    logic                  wr_stb_w;
    logic [ADDR_W-1:0]     wr_addr_w;
    logic [DATA_BITS-1:0]  wr_data_w;
    sctl_state_e           state_w;
    logic [BCNT_W-1:0]     bcnt_w;

    sctl_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk_o),
        .rise_stb (rise_w),
        .fall_stb (fall_w)
    );

    sctl_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_stb (rise_w),
        .fall_stb (fall_w),
        .fs       (fs),
        .sdi      (sdi),
        .dev_addr (dev_addr),
        .rd_addr  (rd_addr_w),
        .rd_data  (rd_data_w),
        .wr_stb   (wr_stb_w),
        .wr_addr  (wr_addr_w),
        .wr_data  (wr_data_w),
        .sdo_o    (sdo_o),
        .sdo_oe   (sdo_oe),
        .state_o  (state_w),
        .bcnt_o   (bcnt_w)
    );

    sctl_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb_w),
        .wr_addr   (wr_addr_w),
        .wr_data   (wr_data_w),
        .rd_addr   (rd_addr_w),
        .rd_data   (rd_data_w),
        .misc_ctl  (misc_ctl),
        .rx_offset (rx_offset)
    );

    assign sclk_oe = (dev_addr == CLK_MASTER_ID);
endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk
    import sctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sclk_o,
    input logic              sdo_oe,
    input logic [5:0]        misc_ctl,
    input logic [15:0]       rx_offset,
    input logic [2:0]        st,
    input logic [BCNT_W-1:0] bcnt,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rise
);
    p_sclk_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> sclk_o);

    p_oe_start_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> (st == 3'(ST_RDOUT)));

    p_skip_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'(ST_SKIP)) |-> !sdo_oe);

    p_write_last_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (bcnt == BCNT_W'(FRAME_BITS - 1)) && (st == 3'(ST_WDATA)));

    p_undef_noop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr != 4'd7 && wr_addr != 4'd9 && wr_addr != 4'd10)
        |=> $stable(misc_ctl) && $stable(rx_offset));

    p_regs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(misc_ctl) && $stable(rx_offset));
endmodule

bind sctl_port sctl_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_o    (sclk_o),
    .sdo_oe    (sdo_oe),
    .misc_ctl  (misc_ctl),
    .rx_offset (rx_offset),
    .st        (state_w),
    .bcnt      (bcnt_w),
    .wr_stb    (wr_stb_w),
    .wr_addr   (wr_addr_w),
    .rise      (rise_w)
);

// File: tb/sctl_port_tb.sv
module sctl_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int WDOG_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  dev_addr = 2'd0;
    logic        fs = 1'b0;
    logic        sdi = 1'b0;
    logic        sclk_o, sclk_oe, sdo_o, sdo_oe;
    logic [5:0]  misc_ctl;
    logic [15:0] rx_offset;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [5:0]  m_misc = '0;
    logic [15:0] m_ofs  = '0;

    sctl_port #(.SCLK_HALF(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .fs(fs), .sdi(sdi),
        .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
        .misc_ctl(misc_ctl), .rx_offset(rx_offset)
    );

    always #(CLK_PERIOD/2) clk = !clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        case (a)
            4'd7:    return {2'b00, m_misc};
            4'd9:    return m_ofs[7:0];
            4'd10:   return m_ofs[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_write(input logic [3:0] a, input logic [7:0] d);
        case (a)
            4'd7:    m_misc = d[5:0];
            4'd9:    m_ofs[7:0] = d;
            4'd10:   m_ofs[15:8] = d;
            default: ;
        endcase
    endfunction

    task automatic idle_bit();
        @(negedge sclk_o); #1;
        fs = 1'b0; sdi = 1'b0;
        @(posedge sclk_o); #1;
    endtask

    // one frame; fs_hold keeps frame-sync high for all 16 bits
    task automatic frame(input logic [15:0] w, input bit fs_hold,
                         output logic [7:0] rd, output int oe_cnt);
        rd = '0; oe_cnt = 0;
        for (int i = 15; i >= 0; i--) begin
            @(negedge sclk_o); #1;
            fs  = (i == 15) || fs_hold;
            sdi = w[i];
            @(posedge sclk_o); #1;
            if (sdo_oe) oe_cnt++;
            if (i <= 7) rd[i] = sdo_o;
        end
    endtask

    task automatic run_frame(input bit rw, input logic [1:0] id, input logic [3:0] a,
                             input logic [7:0] d, input bit fs_hold, input string tag);
        logic [15:0] w;
        logic [7:0]  rd, exp;
        int          oe_cnt;
        bit          hit;
        w   = {rw, id, a, 1'b0, d};
        hit = (id == dev_addr);
        exp = exp_read(a);
        frame(w, fs_hold, rd, oe_cnt);
        if (hit && rw) begin
            chk(oe_cnt == 8, {tag, " R8 oe bit times"}, oe_cnt, 8);
            chk(rd == exp, {tag, " R8 read byte"}, rd, exp);
        end else begin
            chk(oe_cnt == 0, {tag, " R4 oe quiet"}, oe_cnt, 0);
        end
        if (hit && !rw) model_write(a, d);
        chk(misc_ctl == m_misc, {tag, " R5 misc_ctl"}, misc_ctl, m_misc);
        chk(rx_offset == m_ofs, {tag, " R6 rx_offset"}, rx_offset, m_ofs);
    endtask

    initial begin : wdog
        for (int c = 0; c < WDOG_LIMIT; c++) begin
            @(posedge clk);
            if (done) disable wdog;
        end
        chk(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        realtime t0, t1;
        void'($urandom(32'h1d5c_0a71));
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        chk(misc_ctl == 6'h0, "R9 misc reset", misc_ctl, 0);
        chk(rx_offset == 16'h0, "R9 offset reset", rx_offset, 0);
        chk(!sdo_oe, "R9 sdo_oe reset", sdo_oe, 0);
        chk(!sclk_o, "R1 sclk low in reset", sclk_o, 0);
        rst_n = 1'b1;

        // R1: period and pad enable
        @(posedge sclk_o); t0 = $realtime;
        @(posedge sclk_o); t1 = $realtime;
        chk(int'(t1 - t0) == 2*HALF*CLK_PERIOD, "R1 sclk period",
            int'(t1 - t0), 2*HALF*CLK_PERIOD);
        for (int a = 0; a < 4; a++) begin
            dev_addr = 2'(a); #1;
            chk(sclk_oe == (a == 0), "R1 sclk_oe", sclk_oe, a == 0);
        end

        // directed corner cases, device 2
        dev_addr = 2'd2;
        idle_bit();
        run_frame(0, 2'd2, 4'd7, 8'hFF, 0, "R5 misc bits 7:6 dropped");
        run_frame(1, 2'd2, 4'd7, 8'h00, 0, "R5 misc readback");
        run_frame(0, 2'd2, 4'd9, 8'hA5, 0, "R6 offset low");
        run_frame(0, 2'd2, 4'd10, 8'h3C, 0, "R6 offset high");
        run_frame(1, 2'd2, 4'd10, 8'h00, 0, "R3 read offset high");
        run_frame(0, 2'd2, 4'd8, 8'h77, 0, "R7 reserved write");
        run_frame(1, 2'd2, 4'd8, 8'h00, 0, "R7 reserved read");
        run_frame(1, 2'd2, 4'd0, 8'h00, 0, "R7 undefined read");
        run_frame(0, 2'd1, 4'd9, 8'h11, 0, "R4 other id write");
        run_frame(1, 2'd3, 4'd9, 8'h00, 0, "R4 other id read");
        run_frame(0, 2'd2, 4'd7, 8'h15, 1, "R2 fs held in frame");
        idle_bit();
        run_frame(1, 2'd2, 4'd7, 8'h00, 0, "R2 after held fs");

        // constrained random, often back-to-back
        for (int n = 0; n < 240; n++) begin
            logic [1:0] id;
            logic [3:0] a;
            int         pick;
            if (n % 60 == 0) begin
                idle_bit();
                dev_addr = 2'($urandom % 4);
            end
            id   = ($urandom % 4 == 0) ? 2'($urandom % 4) : dev_addr;
            pick = $urandom % 5;
            a    = (pick == 0) ? 4'd7 : (pick == 1) ? 4'd9 : (pick == 2) ? 4'd10 :
                   (pick == 3) ? 4'd8 : 4'($urandom);
            run_frame(1'($urandom), id, a, 8'($urandom), ($urandom % 8 == 0),
                      "R2 R3 random frame");
            if ($urandom % 3 == 0) idle_bit();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule